// File: doc/BRIEF.md
# Masked SIMD Float Multiply / Multiply-Add Unit

This unit executes one vector operation per issue on 512-bit operands. Each operand holds sixteen single-precision lanes. Every lane computes its result in the same pass, so one issue yields one full vector. Two operations exist. The first is a lane-wise product. The second is a product plus an addend, where the addend is the incoming destination value.

A 16-bit write mask sets which lanes take the new value. Lanes whose mask bit is clear pass the old destination contents through unchanged. The unit therefore merges its results into an existing register image. The register file, operand fetch and decode sit outside this unit, which only sees the operand values, the mask and the opcode.

The pipeline has two stages and a fixed latency. Stage one multiplies. Stage two adds and merges. A new operation can be issued on every clock.

Top module: `vmu_unit`

## Requirements
- R1: Lane i occupies bits [32*i+31:32*i] of each vector port and is governed by bit i of `mask_i`; lanes compute independently.
- R2: `valid_o` is asserted exactly two cycles after `valid_i`, and an operation may be issued on every consecutive cycle.
- R3: Opcode 0 gives, in each enabled lane, the product of the two sources, rounded to nearest with ties to even.
- R4: Opcode 1 gives, in each enabled lane, round(round(a*b) + dst), with each of the two steps rounded to nearest-even.
- R5: A lane whose mask bit is 0 returns its incoming destination value unchanged.
- R6: Opcodes 2 and 3 return the incoming destination value in all lanes, whatever the mask.
- R7: A NaN operand, infinity times zero, or the sum of opposite infinities yields the canonical quiet NaN 32'h7FC00000.
- R8: A result whose magnitude exceeds the largest finite value becomes an infinity with the correct sign.
- R9: Inputs with a zero exponent field count as signed zeros. Results below the smallest normal magnitude after rounding become a zero carrying the result's sign.
- R10: After reset `valid_o` and `result_o` are 0, and `result_o` holds its value through cycles that carry no new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation issue strobe |
| op_i | input | 2 | Opcode: 0 multiply, 1 multiply-add, others pass destination |
| mask_i | input | 16 | Per-lane write enable |
| src_a_i | input | 512 | First source vector |
| src_b_i | input | 512 | Second source vector |
| dst_i | input | 512 | Current destination value, also the addend |
| valid_o | output | 1 | Result valid, two cycles after issue |
| result_o | output | 512 | Merged result vector |

## Verification
The second stage adds and merges one operation while the first stage multiplies the next. Consecutive issues could therefore mix up products, addends or masks. The bench sends unbroken runs of issues in which opcode, mask and data all change on every cycle. Each returned lane is compared with a reference that is computed separately in double precision. That reference rounds the product once and the sum once, so any state carried into the wrong operation shows up as a lane mismatch in the cycle where it surfaces.

// File: rtl/vmu_pkg.sv
package vmu_pkg;
  localparam int unsigned FP_W  = 32;
  localparam int unsigned EXP_W = 8;
  localparam int unsigned MAN_W = 23;
  localparam int unsigned OP_W  = 2;
  localparam logic [FP_W-1:0] QNAN = 32'h7FC0_0000;
  localparam logic [OP_W-1:0] OP_MUL = 2'd0;
  localparam logic [OP_W-1:0] OP_FMA = 2'd1;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [MAN_W-1:0] man;
  } fp32_t;

  function automatic logic [4:0] lead_zeros(input logic [26:0] v);
    logic [4:0] n;
    logic       hit;
    n   = 5'd27;
    hit = 1'b0;
    for (int i = 26; i >= 0; i--) begin
      if (!hit && v[i]) begin
        n   = 5'(26 - i);
        hit = 1'b1;
      end
    end
    return n;
  endfunction
endpackage

// File: rtl/vmu_fp_mul.sv
module vmu_fp_mul
  import vmu_pkg::*;
(
  input  logic [FP_W-1:0] a_i,
  input  logic [FP_W-1:0] b_i,
  output logic [FP_W-1:0] y_o
);
  fp32_t a, b;
  logic  s, a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;
  logic [47:0] prod;
  logic signed [10:0] e_raw, e_nrm, e_rnd;
  logic [23:0] m_pre;
  logic        g, st;
  logic [24:0] m_rnd;

  always_comb begin
    a = a_i;
    b = b_i;
    s = a.sign ^ b.sign;
    a_nan  = (a.exp == 8'hFF) && (a.man != '0);
    b_nan  = (b.exp == 8'hFF) && (b.man != '0);
    a_inf  = (a.exp == 8'hFF) && (a.man == '0);
    b_inf  = (b.exp == 8'hFF) && (b.man == '0);
    a_zero = (a.exp == '0);  // denormals flushed
    b_zero = (b.exp == '0);
    prod   = {1'b1, a.man} * {1'b1, b.man};
    e_raw  = $signed({3'b000, a.exp}) + $signed({3'b000, b.exp}) - 11'sd127;
    if (prod[47]) begin
      m_pre = prod[47:24];
      g     = prod[23];
      st    = |prod[22:0];
      e_nrm = e_raw + 11'sd1;
    end else begin
      m_pre = prod[46:23];
      g     = prod[22];
      st    = |prod[21:0];
      e_nrm = e_raw;
    end
    m_rnd = {1'b0, m_pre} + 25'(g & (st | m_pre[0]));
    e_rnd = e_nrm + $signed({10'd0, m_rnd[24]});

    if (a_nan || b_nan || (a_inf && b_zero) || (b_inf && a_zero)) y_o = QNAN;
    else if (a_inf || b_inf)                 y_o = {s, 8'hFF, 23'd0};
    else if (a_zero || b_zero)               y_o = {s, 31'd0};
    else if (e_rnd >= 11'sd255)              y_o = {s, 8'hFF, 23'd0};
    else if (e_rnd <= 11'sd0)                y_o = {s, 31'd0};
    else y_o = {s, e_rnd[7:0], m_rnd[24] ? 23'd0 : m_rnd[22:0]};
  end

  always_comb begin
    if (a_nan || b_nan) p_mul_nan_r7: assert (y_o == QNAN);
    p_mul_ftz_r9: assert (!((y_o[30:23] == 8'd0) && (y_o[22:0] != 23'd0)));
    if (!a_nan && !b_nan && !a_inf && !b_inf && y_o[30:0] == {8'hFF, 23'd0})
      p_mul_ovf_sign_r8: assert (y_o[31] == s);
  end
endmodule

// File: rtl/vmu_fp_add.sv
module vmu_fp_add
  import vmu_pkg::*;
(
  input  logic [FP_W-1:0] a_i,
  input  logic [FP_W-1:0] b_i,
  output logic [FP_W-1:0] y_o
);
  fp32_t a, b, big, sml;
  logic  a_nan, b_nan, a_inf, b_inf, a_zero, b_zero, eff_sub, stk, g, rs;
  logic [7:0]  dexp;
  logic [26:0] ma, mb_full, mb, nrm;
  logic [27:0] sum;
  logic [4:0]  lz;
  logic signed [10:0] e_nrm, e_rnd;
  logic [24:0] m_rnd;

  always_comb begin
    a = a_i;
    b = b_i;
    a_nan  = (a.exp == 8'hFF) && (a.man != '0);
    b_nan  = (b.exp == 8'hFF) && (b.man != '0);
    a_inf  = (a.exp == 8'hFF) && (a.man == '0);
    b_inf  = (b.exp == 8'hFF) && (b.man == '0);
    a_zero = (a.exp == '0);
    b_zero = (b.exp == '0);
    eff_sub = a.sign ^ b.sign;
    if ({b.exp, b.man} > {a.exp, a.man}) begin
      big = b; sml = a;
    end else begin
      big = a; sml = b;
    end
    dexp    = big.exp - sml.exp;
    ma      = {1'b1, big.man, 3'b000};
    mb_full = {1'b1, sml.man, 3'b000};
    // alignment with guard, round and sticky bits
    if (dexp >= 8'd27) begin
      mb  = 27'd1;
      stk = 1'b1;
    end else begin
      stk = |(mb_full & ((27'd1 << dexp) - 27'd1));
      mb  = (mb_full >> dexp) | {26'd0, stk};
    end
    sum = eff_sub ? ({1'b0, ma} - {1'b0, mb}) : ({1'b0, ma} + {1'b0, mb});
    lz  = lead_zeros(sum[26:0]);
    if (sum[27]) begin
      nrm   = {sum[27:2], sum[1] | sum[0]};
      e_nrm = $signed({3'b000, big.exp}) + 11'sd1;
    end else begin
      nrm   = sum[26:0] << lz;
      e_nrm = $signed({3'b000, big.exp}) - $signed({6'd0, lz});
    end
    g     = nrm[2];
    rs    = nrm[1] | nrm[0];
    m_rnd = {1'b0, nrm[26:3]} + 25'(g & (rs | nrm[3]));
    e_rnd = e_nrm + $signed({10'd0, m_rnd[24]});

    if (a_nan || b_nan || (a_inf && b_inf && eff_sub)) y_o = QNAN;
    else if (a_inf)                 y_o = {a.sign, 8'hFF, 23'd0};
    else if (b_inf)                 y_o = {b.sign, 8'hFF, 23'd0};
    else if (a_zero && b_zero)      y_o = {a.sign & b.sign, 31'd0};
    else if (a_zero)                y_o = b_i;
    else if (b_zero)                y_o = a_i;
    else if (sum == 28'd0)          y_o = 32'd0;
    else if (e_rnd >= 11'sd255)     y_o = {big.sign, 8'hFF, 23'd0};
    else if (e_rnd <= 11'sd0)       y_o = {big.sign, 31'd0};
    else y_o = {big.sign, e_rnd[7:0], m_rnd[24] ? 23'd0 : m_rnd[22:0]};
  end

  always_comb begin
    if (a_nan || b_nan) p_add_nan_r7: assert (y_o == QNAN);
    if (a_inf && b_inf && eff_sub) p_add_inf_diff_r7: assert (y_o == QNAN);
    if (!a_zero || !b_zero) p_add_ftz_r9: assert (!((y_o[30:23] == 8'd0) && (y_o[22:0] != 23'd0)));
  end
endmodule

// File: rtl/vmu_lane.sv
module vmu_lane
  import vmu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            issue_i,
  input  logic            wen_i,
  input  logic [FP_W-1:0] a_i,
  input  logic [FP_W-1:0] b_i,
  input  logic [FP_W-1:0] d_i,
  input  logic            adv_i,
  input  logic [OP_W-1:0] op1_i,
  output logic [FP_W-1:0] res_o
);
  logic [FP_W-1:0] prod_d, prod_q, dst_q, sum_d, new_d, res_d;
  logic            wen_q;

  vmu_fp_mul u_mul (.a_i(a_i), .b_i(b_i), .y_o(prod_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      dst_q  <= '0;
      wen_q  <= 1'b0;
    end else if (issue_i) begin
      prod_q <= prod_d;
      dst_q  <= d_i;
      wen_q  <= wen_i;
    end
  end

  vmu_fp_add u_add (.a_i(prod_q), .b_i(dst_q), .y_o(sum_d));

  always_comb begin
    unique case (op1_i)
      OP_MUL:  new_d = prod_q;
      OP_FMA:  new_d = sum_d;
      default: new_d = dst_q;
    endcase
    res_d = wen_q ? new_d : dst_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    res_o <= '0;
    else if (adv_i) res_o <= res_d;
  end

  p_masked_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wen_q) |=> (res_o == $past(dst_q)));
  p_bad_op_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && op1_i != OP_MUL && op1_i != OP_FMA) |=> (res_o == $past(dst_q)));
  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(res_o));
endmodule

// File: rtl/vmu_unit.sv
module vmu_unit
  import vmu_pkg::*;
#(
  parameter int unsigned LANES = 16,
  localparam int unsigned VEC_W = LANES * FP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [VEC_W-1:0] src_a_i,
  input  logic [VEC_W-1:0] src_b_i,
  input  logic [VEC_W-1:0] dst_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] result_o
);
  logic            v1_q, v2_q;
  logic [OP_W-1:0] op1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q  <= 1'b0;
      v2_q  <= 1'b0;
      op1_q <= OP_MUL;
    end else begin
      v1_q <= valid_i;
      v2_q <= v1_q;
      if (valid_i) op1_q <= op_i;
    end
  end

  assign valid_o = v2_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vmu_lane u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .issue_i(valid_i),
      .wen_i  (mask_i[l]),
      .a_i    (src_a_i[l*FP_W +: FP_W]),
      .b_i    (src_b_i[l*FP_W +: FP_W]),
      .d_i    (dst_i[l*FP_W +: FP_W]),
      .adv_i  (v1_q),
      .op1_i  (op1_q),
      .res_o  (result_o[l*FP_W +: FP_W])
    );
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o);
  p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##2 !valid_o);
endmodule

// File: tb/tb_vmu_unit.sv
`timescale 1ns/1ps
module tb_vmu_unit;
  localparam int L = 16;
  localparam int VW = 512;
  localparam logic [31:0] QN = 32'h7FC0_0000;

  logic clk_i = 1'b0, rst_ni = 1'b0, valid_i = 1'b0;
  logic [1:0]    op_i = '0;
  logic [L-1:0]  mask_i = '0;
  logic [VW-1:0] src_a_i = '0, src_b_i = '0, dst_i = '0;
  logic          valid_o;
  logic [VW-1:0] result_o;
  int checks = 0, errors = 0;

  logic [VW-1:0] qa[8], qb[8], qd[8];
  logic [L-1:0]  qm[8];
  logic [1:0]    qo[8];

  always #2.5 clk_i = ~clk_i;

  vmu_unit dut (.clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .mask_i(mask_i), .src_a_i(src_a_i), .src_b_i(src_b_i), .dst_i(dst_i),
    .valid_o(valid_o), .result_o(result_o));

  function automatic real f2r(input logic [31:0] x);
    logic [63:0] bits;
    bits = {x[31], 11'(int'(x[30:23]) - 127 + 1023), x[22:0], 29'd0};
    return $bitstoreal(bits);
  endfunction

  function automatic logic [31:0] r2f(input real r);
    logic [63:0] bits;
    int e;
    logic [24:0] m;
    bits = $realtobits(r);
    e = int'(bits[62:52]) - 1023 + 127;
    m = {2'b01, bits[51:29]};
    if (bits[28] && ((|bits[27:0]) || m[0])) m = m + 25'd1;
    if (m[24]) e++;
    if (e >= 255) return {bits[63], 8'hFF, 23'd0};
    if (e <= 0) return {bits[63], 31'd0};
    return {bits[63], 8'(e), m[24] ? 23'd0 : m[22:0]};
  endfunction

  function automatic logic is_nan(input logic [31:0] x); return x[30:23] == 8'hFF && x[22:0] != 0; endfunction
  function automatic logic is_inf(input logic [31:0] x); return x[30:23] == 8'hFF && x[22:0] == 0; endfunction
  function automatic logic is_zero(input logic [31:0] x); return x[30:23] == 8'h00; endfunction

  function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    logic s;
    s = a[31] ^ b[31];
    if (is_nan(a) || is_nan(b)) return QN;
    if ((is_inf(a) && is_zero(b)) || (is_inf(b) && is_zero(a))) return QN;
    if (is_inf(a) || is_inf(b)) return {s, 8'hFF, 23'd0};
    if (is_zero(a) || is_zero(b)) return {s, 31'd0};
    return r2f(f2r(a) * f2r(b));
  endfunction

  function automatic logic [31:0] ref_add(input logic [31:0] p, input logic [31:0] d);
    real r;
    if (is_nan(p) || is_nan(d)) return QN;
    if (is_inf(p) && is_inf(d) && p[31] != d[31]) return QN;
    if (is_inf(p)) return p;
    if (is_inf(d)) return d;
    if (is_zero(p) && is_zero(d)) return {p[31] & d[31], 31'd0};
    if (is_zero(p)) return d;
    if (is_zero(d)) return p;
    r = f2r(p) + f2r(d);
    if (r == 0.0) return 32'd0;
    return r2f(r);
  endfunction

  function automatic logic [VW-1:0] ref_vec(input logic [1:0] op, input logic [VW-1:0] a,
      input logic [VW-1:0] b, input logic [VW-1:0] d, input logic [L-1:0] m);
    logic [VW-1:0] v;
    for (int l = 0; l < L; l++) begin
      v[32*l +: 32] = d[32*l +: 32];
      if (m[l] && op == 2'd0) v[32*l +: 32] = ref_mul(a[32*l +: 32], b[32*l +: 32]);
      if (m[l] && op == 2'd1) v[32*l +: 32] = ref_add(ref_mul(a[32*l +: 32], b[32*l +: 32]), d[32*l +: 32]);
    end
    return v;
  endfunction

  function automatic logic [31:0] rnorm(input int lo, input int hi);
    logic [31:0] x;
    x[31]    = 1'($urandom % 2);
    x[30:23] = 8'(lo + int'($urandom % 32'(hi - lo + 1)));
    x[22:0]  = 23'($urandom);
    return x;
  endfunction

  function automatic logic [VW-1:0] rvec(input int lo, input int hi);
    logic [VW-1:0] v;
    for (int l = 0; l < L; l++) v[32*l +: 32] = rnorm(lo, hi);
    return v;
  endfunction

  task automatic check_bit(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic check_vec(input logic [VW-1:0] got, input logic [VW-1:0] exp, input string tag);
    for (int l = 0; l < L; l++) begin
      checks++;
      if (got[32*l +: 32] !== exp[32*l +: 32]) begin
        errors++;
        $display("FAIL %s lane %0d got %h expected %h", tag, l, got[32*l +: 32], exp[32*l +: 32]);
      end
    end
  endtask

  // issue qa..qo[0..n-1] back to back and check each result at its slot
  task automatic run_batch(input int n, input string tag);
    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk_i);
      if (i >= 2) begin
        check_bit(valid_o, 1'b1, {tag, " valid R2"});
        check_vec(result_o, ref_vec(qo[i-2], qa[i-2], qb[i-2], qd[i-2], qm[i-2]), tag);
      end else begin
        check_bit(valid_o, 1'b0, {tag, " quiet R2"});
      end
      if (i < n) begin
        valid_i = 1'b1; op_i = qo[i]; mask_i = qm[i];
        src_a_i = qa[i]; src_b_i = qb[i]; dst_i = qd[i];
      end else begin
        valid_i = 1'b0; src_a_i = rvec(100, 150); dst_i = rvec(100, 150);
      end
    end
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    check_bit(valid_o, 1'b0, "R10 reset valid");
    check_vec(result_o, '0, "R10 reset result");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_bit(valid_o, 1'b0, "R10 after reset valid");
  endtask

  task automatic t_mul;
    for (int k = 0; k < 3; k++) begin
      qa[k] = rvec(110, 145); qb[k] = rvec(110, 145); qd[k] = rvec(100, 150);
      qm[k] = '1; qo[k] = 2'd0;
    end
    qa[0][31:0] = 32'h3FC0_0000; qb[0][31:0] = 32'h4000_0000;     // 1.5*2
    qa[0][63:32] = 32'h3F80_0001; qb[0][63:32] = 32'h3FC0_0000;   // tie, rounds up
    qa[0][95:64] = 32'h3F80_0001; qb[0][95:64] = 32'h3F80_0001;   // below half
    qa[0][127:96] = 32'hBF80_0003; qb[0][127:96] = 32'h3FC0_0000; // negative tie
    run_batch(3, "R3 R1 multiply");
  endtask

  task automatic t_fma;
    for (int k = 0; k < 3; k++) begin
      qa[k] = rvec(120, 135); qb[k] = rvec(120, 135); qd[k] = rvec(115, 140);
      qm[k] = '1; qo[k] = 2'd1;
    end
    qd[0][127:96] = ref_mul(qa[0][127:96], qb[0][127:96]) ^ 32'h8000_0000; // exact cancel
    qd[0][159:128] = 32'h5F00_0000;  // addend dominates
    qd[0][191:160] = 32'h2180_0000;  // addend negligible
    qd[0][223:192] = {~qa[0][223], qa[0][222:192]}; qb[0][223:192] = 32'h3F80_0001; // near cancel
    run_batch(3, "R4 multiply-add");
  endtask

  task automatic t_mask;
    qm[0] = 16'hA5A5; qm[1] = 16'h0000; qm[2] = 16'h0004; qm[3] = 16'h8001;
    for (int k = 0; k < 4; k++) begin
      qa[k] = rvec(115, 140); qb[k] = rvec(115, 140); qd[k] = rvec(115, 140);
      qo[k] = 2'(k % 2);
    end
    run_batch(4, "R5 R1 mask merge");
  endtask

  task automatic t_bad_op;
    for (int k = 0; k < 2; k++) begin
      qa[k] = rvec(115, 140); qb[k] = rvec(115, 140); qd[k] = rvec(115, 140);
      qm[k] = '1; qo[k] = 2'(k + 2);
    end
    run_batch(2, "R6 other opcode");
  endtask

  task automatic t_special;
    for (int k = 0; k < 2; k++) begin
      qa[k] = rvec(120, 130); qb[k] = rvec(120, 130); qd[k] = rvec(120, 130);
      qm[k] = '1; qo[k] = 2'(k);
    end
    for (int k = 0; k < 2; k++) begin
      qa[k][31:0]   = 32'h7FA0_1234;                                  // NaN source
      qb[k][63:32]  = 32'hFFC0_0001;
      qa[k][95:64]  = 32'h7F80_0000; qb[k][95:64] = 32'h0000_0000;    // inf*0
      qa[k][127:96] = 32'hFF80_0000; qb[k][127:96] = 32'hC000_0000;   // -inf*-2
      qa[k][159:128] = 32'h7F7F_FFFF; qb[k][159:128] = 32'h4000_0000; // overflow
      qa[k][191:160] = 32'hFF7F_FFFF; qb[k][191:160] = 32'h4000_0000; // -overflow
      qa[k][223:192] = 32'h7F80_0000; qb[k][223:192] = 32'h3F80_0000;
      qd[k][223:192] = 32'hFF80_0000;                                  // inf-inf on fma
      qd[k][255:224] = 32'h7FC0_0055;                                  // NaN addend
      qd[k][287:256] = 32'h7F80_0000;                                  // inf addend
      qa[k][319:288] = 32'h7F00_0000; qb[k][319:288] = 32'h3F80_0000;
      qd[k][319:288] = 32'h7F00_0000;                                  // sum overflows
    end
    run_batch(2, "R7 R8 specials");
  endtask

  task automatic t_ftz;
    for (int k = 0; k < 2; k++) begin
      qa[k] = rvec(120, 130); qb[k] = rvec(120, 130); qd[k] = rvec(120, 130);
      qm[k] = '1; qo[k] = 2'(k);
      qa[k][31:0]   = 32'h0000_0001; qb[k][31:0] = 32'h4000_0000;     // denormal in
      qa[k][63:32]  = 32'h0D80_0000; qb[k][63:32] = 32'h8D80_0000;    // tiny product, negative
      qa[k][95:64]  = 32'h0380_0001; qb[k][95:64] = 32'h3F80_0000;
      qd[k][95:64]  = 32'h8380_0000;                                   // tiny difference
      qd[k][127:96] = 32'h807F_FFFF;                                   // denormal addend
      qa[k][159:128] = 32'h8000_0000; qd[k][159:128] = 32'h8000_0000;  // -0 + -0
    end
    run_batch(2, "R9 flush to zero");
  endtask

  task automatic t_b2b;
    for (int k = 0; k < 6; k++) begin
      qa[k] = rvec(110, 145); qb[k] = rvec(110, 145); qd[k] = rvec(105, 150);
      qo[k] = 2'(k % 3); qm[k] = 16'($urandom);
    end
    run_batch(6, "R2 back-to-back");
  endtask

  task automatic t_hold;
    logic [VW-1:0] snap;
    snap = result_o;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      src_a_i = rvec(100, 150); dst_i = rvec(100, 150); mask_i = '1; op_i = 2'd1;
      check_bit(valid_o, 1'b0, "R10 idle valid");
      check_vec(result_o, snap, "R10 idle hold");
    end
  endtask

  initial begin
    t_reset();
    t_mul();
    t_fma();
    t_mask();
    t_bad_op();
    t_special();
    t_ftz();
    t_b2b();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule